// File: doc/BRIEF.md
# Protected Multi-Region Register Access Decoder

This block sits behind the byte engine of a two-wire serial target and turns the decoded device-type nibble, the three bus address bits and the word address into region selects for three kinds of storage: a command and status space, a general-purpose byte memory split into a lower and an upper half of 256 bytes each, and a configuration register bank. It also produces one write-enable per storage array. Each write-enable is gated by a volatile protection register that lives in the command space.

The protection register is split into two independent nibbles. The upper nibble unlocks the general-purpose memory and the lower nibble unlocks the configuration bank. Only the pattern 0101 opens a region. Reset locks both regions again. A write to a locked region is still acknowledged, because the address was valid, but no array is enabled.

The selects, the acknowledge and the write-enables are combinational in the current inputs. The protection register is the only state and changes on the clock edge at which a qualifying write strobe is seen. `wr_strobe` is a single-cycle qualifier with no back-pressure: the byte engine presents one complete access per cycle, and the block never stalls it.

Top module: `prot_region_decoder`

## Requirements
- R1: While reset is asserted and after it is released, `wp_rdata` is 0x00 and none of the write-enables can assert until the protection register is written.
- R2: A cycle with `wr_strobe` high, `type_code` = 1001 and `word_addr` = 0x87 loads `wr_data` into the protection register. `wp_rdata` shows the new value from the following cycle onward.
- R3: While bits [7:4] of the protection register equal 0101, a strobed access to either memory half asserts that half's write-enable.
- R4: While bits [3:0] of the protection register equal 0101, a strobed access to the configuration bank asserts `we_cfg`.
- R5: Any other value in a nibble keeps the matching region locked, and so does writing such a value after an unlock.
- R6: With `type_code` 1010 or 1011 and a matching A[2], the low bus bits select a region: `bus_addr[1:0]` = 00 gives `sel_mem_lo`, 01 gives `sel_mem_hi`, 11 gives `sel_cfg`, and 10 gives no select and `ack` low. `ack` is high exactly when some select is high.
- R7: Bus bit A[2] must equal 0 when `a2_src` is 0, and must equal `a2_pin` when `a2_src` is 1. On a mismatch, no memory or configuration region is selected.
- R8: `type_code` 1001 asserts `sel_cmd` and `ack` whatever the bus bits are. Type codes other than 1001, 1010 and 1011 select nothing.
- R9: A strobed access to a locked region still gives `ack` but asserts no write-enable.
- R10: A write-enable is high only while `wr_strobe` is high and its own region is selected, so at most one write-enable is high at a time.
- R11: Strobed writes under type 1001 to any word address other than 0x87, as well as cycles without a strobe, leave `wp_rdata` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| type_code | input | 4 | Decoded device-type nibble |
| bus_addr | input | 3 | Bus address bits A[2:0] |
| word_addr | input | 8 | Word address byte |
| wr_data | input | 8 | Write data byte |
| wr_strobe | input | 1 | One-cycle write qualifier |
| a2_pin | input | 1 | Level of external address pin |
| a2_src | input | 1 | Config bit: 1 compares A[2] with `a2_pin`, 0 compares it with 0 |
| sel_cmd | output | 1 | Command/status space selected |
| sel_mem_lo | output | 1 | Lower memory half selected |
| sel_mem_hi | output | 1 | Upper memory half selected |
| sel_cfg | output | 1 | Configuration bank selected |
| ack | output | 1 | Address is mapped |
| we_mem_lo | output | 1 | Write-enable, lower memory half |
| we_mem_hi | output | 1 | Write-enable, upper memory half |
| we_cfg | output | 1 | Write-enable, configuration bank |
| wp_rdata | output | 8 | Protection register read-back |

## Verification
The bench targets four corner cases:
- **Unmapped pattern 10 on the low bus bits.** A decoder that folds it into the configuration bank would acknowledge the access and could enable a write there.
- **Near-miss nibbles such as 0100 or 0111.** A partial compare would unlock a region on these.
- **Independence of the two nibbles.** A shared unlock would open both regions at once.
- **The A[2] comparison in both `a2_src` settings.** Getting this wrong makes the target answer to a neighbour's address.

The bench also checks that a protection write affects the write-enables only from the next cycle. It also checks that nearby command-space addresses such as 0x86 and 0x88 never disturb the protection register.

// File: rtl/prd_pkg.sv
package prd_pkg;
  typedef enum logic [2:0] {
    RG_NONE = 3'd0,
    RG_CMD  = 3'd1,
    RG_MLO  = 3'd2,
    RG_MHI  = 3'd3,
    RG_CFG  = 3'd4
  } region_t;

  localparam logic [1:0] BA_MLO = 2'b00;
  localparam logic [1:0] BA_MHI = 2'b01;
  localparam logic [1:0] BA_CFG = 2'b11;
endpackage

// File: rtl/prd_addr_match.sv
module prd_addr_match
  import prd_pkg::*;
#(
  parameter int TYPE_W = 4,
  parameter int BUS_W = 3,
  parameter logic [TYPE_W-1:0] CMD_TYPE = 4'b1001,
  parameter logic [TYPE_W-1:0] MEM_TYPE_A = 4'b1010,
  parameter logic [TYPE_W-1:0] MEM_TYPE_B = 4'b1011
) (
  input  logic [TYPE_W-1:0] type_code,
  input  logic [BUS_W-1:0]  bus_addr,
  input  logic              a2_pin,
  input  logic              a2_src,
  output region_t           region
);
  localparam int HI_BIT = BUS_W - 1;

  logic hi_expect;
  logic hi_ok;

  assign hi_expect = a2_src ? a2_pin : 1'b0;
  assign hi_ok = (bus_addr[HI_BIT] == hi_expect);

  always_comb begin
    region = RG_NONE;
    if (type_code == CMD_TYPE) begin
      region = RG_CMD;
    end else if ((type_code == MEM_TYPE_A || type_code == MEM_TYPE_B) && hi_ok) begin
      unique case (bus_addr[1:0])
        BA_MLO:  region = RG_MLO;
        BA_MHI:  region = RG_MHI;
        BA_CFG:  region = RG_CFG;
        default: region = RG_NONE;
      endcase
    end
  end
endmodule

// File: rtl/prd_wp_reg.sv
module prd_wp_reg
  import prd_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] WP_ADDR = 8'h87,
  parameter logic [DATA_W/2-1:0] UNLOCK = 4'b0101
) (
  input  logic              clk,
  input  logic              rst_n,
  input  region_t           region,
  input  logic [ADDR_W-1:0] word_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_strobe,
  output logic [DATA_W-1:0] wp_q,
  output logic              mem_unlock,
  output logic              cfg_unlock
);
  localparam int NIB_W = DATA_W / 2;

  logic wp_hit;

  assign wp_hit = wr_strobe && (region == RG_CMD) && (word_addr == WP_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wp_q <= '0;
    else if (wp_hit) wp_q <= wr_data;
  end

  assign mem_unlock = (wp_q[DATA_W-1 -: NIB_W] == UNLOCK);
  assign cfg_unlock = (wp_q[NIB_W-1:0] == UNLOCK);

  a_r1_reset_locked: assert property (@(posedge clk) !rst_n |=> (wp_q == '0));
  a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
    wp_hit |=> (wp_q == $past(wr_data)));
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wp_hit |=> $stable(wp_q));
endmodule

// File: rtl/prot_region_decoder.sv
module prot_region_decoder
  import prd_pkg::*;
#(
  parameter int TYPE_W = 4,
  parameter int BUS_W = 3,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [TYPE_W-1:0] CMD_TYPE = 4'b1001,
  parameter logic [TYPE_W-1:0] MEM_TYPE_A = 4'b1010,
  parameter logic [TYPE_W-1:0] MEM_TYPE_B = 4'b1011,
  parameter logic [ADDR_W-1:0] WP_ADDR = 8'h87,
  parameter logic [DATA_W/2-1:0] UNLOCK = 4'b0101
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TYPE_W-1:0] type_code,
  input  logic [BUS_W-1:0]  bus_addr,
  input  logic [ADDR_W-1:0] word_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_strobe,
  input  logic              a2_pin,
  input  logic              a2_src,
  output logic              sel_cmd,
  output logic              sel_mem_lo,
  output logic              sel_mem_hi,
  output logic              sel_cfg,
  output logic              ack,
  output logic              we_mem_lo,
  output logic              we_mem_hi,
  output logic              we_cfg,
  output logic [DATA_W-1:0] wp_rdata
);
  localparam int N_ARR = 3;

  region_t region;
  logic mem_unlock;
  logic cfg_unlock;
  logic [N_ARR-1:0] arr_sel;
  logic [N_ARR-1:0] arr_open;
  logic [N_ARR-1:0] arr_we;

  prd_addr_match #(
    .TYPE_W(TYPE_W), .BUS_W(BUS_W), .CMD_TYPE(CMD_TYPE),
    .MEM_TYPE_A(MEM_TYPE_A), .MEM_TYPE_B(MEM_TYPE_B)
  ) u_match (
    .type_code(type_code), .bus_addr(bus_addr), .a2_pin(a2_pin),
    .a2_src(a2_src), .region(region)
  );

  prd_wp_reg #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WP_ADDR(WP_ADDR), .UNLOCK(UNLOCK)
  ) u_wp (
    .clk(clk), .rst_n(rst_n), .region(region), .word_addr(word_addr),
    .wr_data(wr_data), .wr_strobe(wr_strobe), .wp_q(wp_rdata),
    .mem_unlock(mem_unlock), .cfg_unlock(cfg_unlock)
  );

  assign sel_cmd = (region == RG_CMD);
  assign arr_sel = {region == RG_CFG, region == RG_MHI, region == RG_MLO};
  assign arr_open = {cfg_unlock, mem_unlock, mem_unlock};

  for (genvar i = 0; i < N_ARR; i++) begin : g_we
    assign arr_we[i] = wr_strobe && arr_sel[i] && arr_open[i];
  end

  assign sel_mem_lo = arr_sel[0];
  assign sel_mem_hi = arr_sel[1];
  assign sel_cfg = arr_sel[2];
  assign ack = (region != RG_NONE);
  assign we_mem_lo = arr_we[0];
  assign we_mem_hi = arr_we[1];
  assign we_cfg = arr_we[2];

  a_r6_one_select: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sel_cmd, sel_mem_lo, sel_mem_hi, sel_cfg}));
  a_r9_mem_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (we_mem_lo || we_mem_hi) |-> (wp_rdata[DATA_W-1 -: DATA_W/2] == UNLOCK));
  a_r9_cfg_locked: assert property (@(posedge clk) disable iff (!rst_n)
    we_cfg |-> (wp_rdata[DATA_W/2-1:0] == UNLOCK));
  a_r10_we_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (we_mem_lo || we_mem_hi || we_cfg) |-> (wr_strobe && ack));
  a_r10_we_single: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({we_mem_lo, we_mem_hi, we_cfg}));
endmodule

// File: tb/sim_prot_region_decoder.sv
module sim_prot_region_decoder;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] type_code = '0;
  logic [2:0] bus_addr = '0;
  logic [7:0] word_addr = '0;
  logic [7:0] wr_data = '0;
  logic wr_strobe = 1'b0;
  logic a2_pin = 1'b0;
  logic a2_src = 1'b0;
  logic sel_cmd, sel_mem_lo, sel_mem_hi, sel_cfg, ack;
  logic we_mem_lo, we_mem_hi, we_cfg;
  logic [7:0] wp_rdata;

  int n_checks = 0;
  int n_errors = 0;
  logic [7:0] wp_model = 8'h00;
  bit done = 1'b0;

  always #10 clk = ~clk;

  prot_region_decoder u0 (
    .clk(clk), .rst_n(rst_n), .type_code(type_code), .bus_addr(bus_addr),
    .word_addr(word_addr), .wr_data(wr_data), .wr_strobe(wr_strobe),
    .a2_pin(a2_pin), .a2_src(a2_src), .sel_cmd(sel_cmd), .sel_mem_lo(sel_mem_lo),
    .sel_mem_hi(sel_mem_hi), .sel_cfg(sel_cfg), .ack(ack), .we_mem_lo(we_mem_lo),
    .we_mem_hi(we_mem_hi), .we_cfg(we_cfg), .wp_rdata(wp_rdata)
  );

  task automatic check(string tag, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // expected selects as {cmd, lo, hi, cfg}
  function automatic logic [3:0] exp_sel(logic [3:0] t, logic [2:0] b, logic pin, logic src);
    logic hi_ok;
    hi_ok = (b[2] == (src ? pin : 1'b0));
    if (t == 4'b1001) return 4'b1000;
    if ((t == 4'b1010 || t == 4'b1011) && hi_ok) begin
      case (b[1:0])
        2'b00: return 4'b0100;
        2'b01: return 4'b0010;
        2'b11: return 4'b0001;
        default: return 4'b0000;
      endcase
    end
    return 4'b0000;
  endfunction

  function automatic logic [2:0] exp_we(logic [3:0] s, logic stb, logic [7:0] wp);
    logic mo, co;
    mo = (wp[7:4] == 4'b0101);
    co = (wp[3:0] == 4'b0101);
    return {stb && s[2] && mo, stb && s[1] && mo, stb && s[0] && co};
  endfunction

  // called at a negedge; checks outputs mid-cycle, then advances one cycle
  task automatic access(string tag, logic [3:0] t, logic [2:0] b, logic [7:0] wa,
                        logic [7:0] d, logic stb, logic pin, logic src);
    logic [3:0] es;
    logic [2:0] ew;
    type_code = t; bus_addr = b; word_addr = wa; wr_data = d;
    wr_strobe = stb; a2_pin = pin; a2_src = src;
    #5;
    es = exp_sel(t, b, pin, src);
    ew = exp_we(es, stb, wp_model);
    check({tag, " sel R6"}, {sel_cmd, sel_mem_lo, sel_mem_hi, sel_cfg}, es);
    check({tag, " ack R6"}, ack, |es);
    check({tag, " we R9"}, {we_mem_lo, we_mem_hi, we_cfg}, ew);
    check({tag, " wp R2"}, wp_rdata, wp_model);
    @(posedge clk);
    if (stb && t == 4'b1001 && wa == 8'h87) wp_model = d;
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check("R1 reset value", wp_rdata, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", wp_rdata, 8'h00);
    access("R1 mem locked", 4'b1010, 3'b000, 8'h10, 8'hAA, 1'b1, 1'b0, 1'b0);
    check("R1 no we mem", we_mem_lo, 0);
    access("R9 cfg locked", 4'b1011, 3'b011, 8'h02, 8'h11, 1'b1, 1'b0, 1'b0);
    // unlock config only
    access("R4 set", 4'b1001, 3'b101, 8'h87, 8'h05, 1'b1, 1'b0, 1'b0);
    check("R2 readback", wp_rdata, 8'h05);
    access("R4 cfg open", 4'b1011, 3'b011, 8'h00, 8'h01, 1'b1, 1'b0, 1'b0);
    access("R5 mem still locked", 4'b1010, 3'b001, 8'h00, 8'h01, 1'b1, 1'b0, 1'b0);
    access("R3 set", 4'b1001, 3'b000, 8'h87, 8'h55, 1'b1, 1'b0, 1'b0);
    access("R3 lo open", 4'b1010, 3'b000, 8'hFF, 8'h01, 1'b1, 1'b0, 1'b0);
    access("R3 hi open", 4'b1011, 3'b001, 8'h00, 8'h01, 1'b1, 1'b0, 1'b0);
    access("R10 no strobe", 4'b1010, 3'b000, 8'h00, 8'h01, 1'b0, 1'b0, 1'b0);
    access("R6 unmapped", 4'b1010, 3'b010, 8'h00, 8'h01, 1'b1, 1'b0, 1'b0);
    access("R11 addr 86", 4'b1001, 3'b000, 8'h86, 8'h00, 1'b1, 1'b0, 1'b0);
    access("R11 addr 88", 4'b1001, 3'b000, 8'h88, 8'h00, 1'b1, 1'b0, 1'b0);
    check("R11 wp held", wp_rdata, 8'h55);
    access("R11 no strobe", 4'b1001, 3'b000, 8'h87, 8'h00, 1'b0, 1'b0, 1'b0);
    check("R11 wp held nostb", wp_rdata, 8'h55);
    access("R7 pin high match", 4'b1010, 3'b100, 8'h00, 8'h01, 1'b1, 1'b1, 1'b1);
    access("R7 pin high miss", 4'b1010, 3'b000, 8'h00, 8'h01, 1'b1, 1'b1, 1'b1);
    access("R7 const zero miss", 4'b1010, 3'b100, 8'h00, 8'h01, 1'b1, 1'b1, 1'b0);
    access("R8 other type", 4'b1100, 3'b000, 8'h00, 8'h01, 1'b1, 1'b0, 1'b0);
    access("R5 near miss", 4'b1001, 3'b000, 8'h87, 8'h47, 1'b1, 1'b0, 1'b0);
    access("R5 mem relocked", 4'b1010, 3'b000, 8'h00, 8'h01, 1'b1, 1'b0, 1'b0);
    access("R5 cfg relocked", 4'b1011, 3'b011, 8'h00, 8'h01, 1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 2000; i++) begin
      logic [3:0] t;
      logic [7:0] wa, d;
      int k;
      k = $urandom_range(0, 9);
      t = (k < 3) ? 4'b1001 : (k < 6) ? 4'b1010 : (k < 9) ? 4'b1011 : 4'($urandom);
      wa = ($urandom_range(0, 3) == 0) ? 8'h87 : 8'($urandom);
      case ($urandom_range(0, 3))
        0: d = 8'h55;
        1: d = {4'b0101, 4'($urandom)};
        2: d = {4'($urandom), 4'b0101};
        default: d = 8'($urandom);
      endcase
      access("rand", t, 3'($urandom), wa, d, 1'($urandom), 1'($urandom), 1'($urandom));
    end
    rst_n = 1'b0;
    #5;
    check("R1 re-reset", wp_rdata, 8'h00);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule